// File: doc/BRIEF.md
# Slow-Clock Counter with Compare Interrupt

This block keeps a 32-bit up-counter running in a low-frequency oscillator domain, nominally 32.768 kHz. Software reaches it through a small register bus in a much faster system clock domain. A prescaler register sets the counting rate. A preload register lets software place a new counter value. A compare register raises a single-cycle interrupt each time the counter steps onto its value.

Every value written for the slow domain crosses over through a toggle handshake. Each such register has its own busy flag in the control word. Software polls that flag before it writes the register again, and a write made while the flag is up is dropped.

The counter value comes back the other way through a snapshot handshake that runs all the time. A sticky flag tells software that the oscillator has produced at least one edge.

Top module: `slow_counter_match`

## Requirements
- R1: After reset every readable register reads zero: the control word, trim, preload, count and match. All busy flags are clear, and so is the clock-seen flag.
- R2: The address map is fixed: 0 control, 1 trim, 2 preload, 3 count (read only), 4 match. In the control word, bit 0 is the writable enable, bit 1 is clock-seen, bit 2 is trim busy, bit 3 is preload busy and bit 4 is match busy.
- R3: A write to trim, preload or match sets that register's busy bit. The bit stays set while the slow clock is stopped, and it clears once the slow domain has taken the value.
- R4: A write to trim, preload or match while its busy bit is set has no effect. The register reads back its earlier value, and the busy bit stays set.
- R5: Once the preload busy bit has cleared, the count register reads the preloaded value, provided counting is disabled.
- R6: While the enable bit is 0 the counter holds its value.
- R7: With trim value N, the enabled counter advances once every N+1 slow-clock ticks. With N = 0 it advances on every tick.
- R8: The counter wraps from 0xFFFFFFFF to 0 and keeps counting.
- R9: `irq` goes high for exactly one system clock cycle each time the counter steps onto the match value. It never goes high when the counter does not reach the match value.
- R10: The clock-seen bit sets after the slow clock has toggled and stays set when the slow clock stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the register bus |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | Low-frequency counting clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Compare-match pulse, one `clk` cycle wide |

## Verification
The bench uses the default parameters: a 32-bit counter and a 16-bit trim field. With a 32-bit counter, the wrap and the compare across zero can only be reached within the run time by preloading a value just below all-ones, so the bench does exactly that. The bench also stops and restarts the slow clock on its own. This makes the busy bits and the clock-seen bit observable while no slow edges arrive.

// File: rtl/slow_counter_match.sv
module slow_counter_match #(
  parameter int CW = 32,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_clk,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_TRIM = 3'd1, A_PRE = 3'd2, A_CNT = 3'd3, A_MAT = 3'd4;

  // system domain
  logic          en, seen;
  logic [TW-1:0] trim_h;
  logic [CW-1:0] pre_h, mat_h, view;
  logic [2:0]    req_t, ack_a1, ack_a2, pend;
  logic          snap_req, snap_a1, snap_a2;
  logic          tk1, tk2, tk3, h1, h2, h3;

  // slow domain
  logic [2:0]    req_s1, req_s2, req_seen, take;
  logic          en_s1, en_s2, tick_t, hit_t;
  logic          snap_s1, snap_s2, snap_seen;
  logic [TW-1:0] trim_s, presc;
  logic [CW-1:0] cnt, mat_s, snap, cnt_inc;
  logic          step;

  assign pend    = req_t ^ ack_a2;
  assign take    = req_s2 ^ req_seen;
  assign step    = en_s2 && (presc == trim_s);
  assign cnt_inc = cnt + 1'b1;
  assign irq     = h2 ^ h3;

  wire wr_trim = wr_en && addr == A_TRIM && !pend[0];
  wire wr_pre  = wr_en && addr == A_PRE  && !pend[1];
  wire wr_mat  = wr_en && addr == A_MAT  && !pend[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; seen <= 1'b0;
      trim_h <= '0; pre_h <= '0; mat_h <= '0; view <= '0;
      req_t <= '0; ack_a1 <= '0; ack_a2 <= '0;
      snap_req <= 1'b0; snap_a1 <= 1'b0; snap_a2 <= 1'b0;
      tk1 <= 1'b0; tk2 <= 1'b0; tk3 <= 1'b0;
      h1 <= 1'b0; h2 <= 1'b0; h3 <= 1'b0;
    end else begin
      ack_a1 <= req_seen; ack_a2 <= ack_a1;
      snap_a1 <= snap_seen; snap_a2 <= snap_a1;
      tk1 <= tick_t; tk2 <= tk1; tk3 <= tk2;
      h1 <= hit_t; h2 <= h1; h3 <= h2;
      if (tk2 != tk3) seen <= 1'b1;
      if (snap_a2 == snap_req) begin
        view     <= snap;
        snap_req <= ~snap_req;
      end
      if (wr_en && addr == A_CTRL) en <= wdata[0];
      if (wr_trim) begin trim_h <= wdata[TW-1:0]; req_t[0] <= ~req_t[0]; end
      if (wr_pre)  begin pre_h  <= wdata;         req_t[1] <= ~req_t[1]; end
      if (wr_mat)  begin mat_h  <= wdata;         req_t[2] <= ~req_t[2]; end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[4:0] = {pend, seen, en};
      A_TRIM:  rdata[TW-1:0] = trim_h;
      A_PRE:   rdata = pre_h;
      A_CNT:   rdata = view;
      A_MAT:   rdata = mat_h;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= '0; req_s2 <= '0; req_seen <= '0;
      en_s1 <= 1'b0; en_s2 <= 1'b0; tick_t <= 1'b0; hit_t <= 1'b0;
      snap_s1 <= 1'b0; snap_s2 <= 1'b0; snap_seen <= 1'b0;
      trim_s <= '0; presc <= '0; cnt <= '0; mat_s <= '0; snap <= '0;
    end else begin
      req_s1 <= req_t; req_s2 <= req_s1; req_seen <= req_s2;
      en_s1 <= en; en_s2 <= en_s1;
      tick_t <= ~tick_t;
      snap_s1 <= snap_req; snap_s2 <= snap_s1;
      if (snap_s2 != snap_seen) begin
        snap      <= cnt;
        snap_seen <= snap_s2;
      end
      if (take[0]) begin
        trim_s <= trim_h;
        presc  <= '0;
      end else if (en_s2) begin
        presc <= step ? '0 : presc + 1'b1;
      end
      if (take[2]) mat_s <= mat_h;
      if (take[1]) cnt <= pre_h;
      else if (step) begin
        cnt <= cnt_inc;
        if (cnt_inc == mat_s) hit_t <= ~hit_t;
      end
    end
  end

  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) seen |=> seen); // R10
  AST_BUSY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PRE && !pend[1]) |=> pend[1]); // R3
  AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TRIM && pend[0]) |=> ($stable(trim_h) && pend[0])); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R9
  AST_PRESC_BOUND: assert property (@(posedge slow_clk) disable iff (!rst_n) presc <= trim_s); // R7
  AST_HOLD_DISABLED: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (!en_s2 && !take[1]) |=> $stable(cnt)); // R6
endmodule

// File: tb/sim_slow_counter_match.sv
module sim_slow_counter_match;
  logic        clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0, slow_run = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, errors = 0, irq_cnt = 0;

  slow_counter_match u0 (.clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;
  initial forever begin #33; if (slow_run) slow_clk = ~slow_clk; end
  always @(negedge clk) if (irq) irq_cnt++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd0, c);
      if (c[4:2] == 3'b000) return;
    end
    check(1'b0, "R3 busy never cleared", c, 0);
  endtask

  task automatic settle();
    repeat (10) @(posedge slow_clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic longint steps(input int k, input int n);
    return k / (n + 1);
  endfunction

  task automatic run_window(input int k, input int n, output logic [31:0] got);
    wr(3'd0, 32'd1);
    repeat (k) @(posedge slow_clk);
    wr(3'd0, 32'd0);
    settle();
    rd(3'd3, got);
  endtask

  initial begin
    logic [31:0] v;
    longint e;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v); check(v == 0, "R1 reset value", v, 0);
    end

    wr(3'd1, 32'd3);
    rd(3'd0, v); check(v[2] == 1'b1, "R3 trim busy set", v, 32'h4);
    wr(3'd1, 32'd7);
    rd(3'd1, v); check(v == 3, "R4 trim write while busy dropped", v, 3);
    rd(3'd0, v); check(v[2] == 1'b1, "R4 busy unchanged", v, 32'h4);
    wr(3'd2, 32'h1234);
    wr(3'd4, 32'h5);
    repeat (20) @(negedge clk);
    rd(3'd0, v); check(v == 32'h1C, "R3 R2 busy bits held, clock not seen", v, 32'h1C);

    slow_run = 1'b1;
    wait_idle();
    rd(3'd0, v); check(v == 32'h2, "R10 clock seen, busy clear", v, 2);
    settle();
    rd(3'd3, v); check(v == 32'h1234, "R5 preload read back", v, 32'h1234);
    repeat (20) @(posedge slow_clk); settle();
    rd(3'd3, v); check(v == 32'h1234, "R6 disabled counter holds", v, 32'h1234);

    slow_run = 1'b0;
    repeat (60) @(negedge clk);
    rd(3'd0, v); check(v[1] == 1'b1, "R10 sticky with slow clock stopped", v, 2);
    slow_run = 1'b1;

    wr(3'd2, 32'd0); wr(3'd4, 32'hF000_0000); wait_idle();
    run_window(80, 3, v); e = steps(80, 3);
    check(v >= e - 2 && v <= e + 2, "R7 trim 3 rate", v, e);
    wr(3'd1, 32'd0); wr(3'd2, 32'd0); wait_idle();
    run_window(40, 0, v); e = 40;
    check(v >= e - 2 && v <= e + 2, "R7 trim 0 full rate", v, e);
    check(irq_cnt == 0, "R9 no irq when match unreached", irq_cnt, 0);

    wr(3'd2, 32'hFFFF_FFFE); wr(3'd4, 32'h1); wait_idle();
    irq_cnt = 0;
    run_window(6, 0, v);
    check(v >= 1 && v <= 9, "R8 wrap past all-ones", v, 4);
    check(irq_cnt == 1, "R9 single irq at match across wrap", irq_cnt, 1);

    for (int it = 0; it < 8; it++) begin
      int n, k, m;
      logic [31:0] p;
      bit hit;
      n = $urandom_range(0, 4);
      k = (n + 1) * $urandom_range(8, 16);
      p = $urandom();
      hit = $urandom_range(0, 1) == 1;
      e = steps(k, n);
      m = $urandom_range(1, int'(e) - 3);
      wr(3'd1, n); wr(3'd2, p); wr(3'd4, hit ? p + m : p - 5); wait_idle();
      irq_cnt = 0;
      run_window(k, n, v);
      check((v - p) >= e - 2 && (v - p) <= e + 2, "R7 random rate", v - p, e);
      check(irq_cnt == (hit ? 1 : 0), "R9 random match", irq_cnt, hit ? 1 : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule